// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Holding Buffer

This block turns bytes written by a processor into an asynchronous serial character stream. A write places the byte into a holding register. On the next pulse of a 16x baud enable, the byte moves into a shift register, which frames it with a start bit, 5 to 8 data bits, an optional parity bit and a stop period. Because the two registers are separate, software can load the next byte while the current one is still shifting out. Characters then follow each other with no idle gap.

Two status flags report progress. One says the holding register can take another byte. The other says the whole transmitter, holding register and shifter both, has gone quiet. A break input drives the line to the spacing level at any time. The baud divisor, the register decoding and the interrupt logic sit outside this block. The block receives the baud enable as `tick_i` and the frame format as plain control pins. The format pins are captured when a character is launched.

Top module: `uart_tx_core`

## Requirements
- R1: During and after reset, `txd_o` is 1 and both `hold_empty_o` and `tx_empty_o` are 1. The holding register resets to zero.
- R2: A character is sent as follows. First a start bit at 0. Then the data bits, least significant bit first. The number of data bits is 5 + `char_len_i` (code 0 gives 5 bits, code 3 gives 8 bits). Every bit lasts exactly 16 pulses of `tick_i`.
- R3: When `par_en_i` is 1, one parity bit follows the data. With `par_even_i` = 1 it is the XOR of the sent data bits. With `par_even_i` = 0 it is the inverse of that XOR. Data bits above the character length have no effect on it.
- R4: When `stop_two_i` is 0, the stop level (1) lasts 16 ticks. When it is 1, the stop level lasts 32 ticks, except with 5-bit characters, where it lasts 24 ticks.
- R5: A written byte does not start before a tick. The start bit appears on `txd_o` at the first tick edge that follows the write edge.
- R6: After a write to an idle block, both flags still read 1 after the clock edge that samples the write, and both read 0 after the next edge. `hold_empty_o` returns to 1 at the tick that moves the byte into the shifter.
- R7: A byte written while another is shifting is held. It launches at the tick that ends the previous stop period, so its start bit follows that stop period directly.
- R8: `tx_empty_o` returns to 1 at the tick that ends the last stop period when no byte is held. Whenever `tx_empty_o` is 1, `hold_empty_o` is 1 and the line is at 1 unless break is active.
- R9: While `break_i` is 1, `txd_o` is 0. The character timing keeps running underneath. After release, the line shows the frame bit due at that point.
- R10: `char_len_i`, `par_en_i`, `par_even_i` and `stop_two_i` are captured at launch. Changing them mid-character does not alter the character being sent.
- R11: Apart from a change of `break_i`, `txd_o` changes only at a clock edge where `tick_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 16x baud enable, one cycle per pulse |
| hold_wr_i | input | 1 | Write strobe for the holding register |
| hold_data_i | input | 8 | Byte to transmit |
| char_len_i | input | 2 | Character length code, data bits = 5 + code |
| par_en_i | input | 1 | Parity bit enable |
| par_even_i | input | 1 | 1 = even parity, 0 = odd parity |
| stop_two_i | input | 1 | Long stop period (2 bits, or 1.5 bits for 5-bit characters) |
| break_i | input | 1 | Force the line low |
| txd_o | output | 1 | Serial output, idles high |
| hold_empty_o | output | 1 | Holding register can accept a byte |
| tx_empty_o | output | 1 | Holding register and shifter both empty |

## Verification
The hardest state to reach is a held byte waiting behind a character that is still shifting. The byte must then launch at exactly the tick that ends the previous stop period. The bench gets there by writing a second byte right after the first launches. Before the first character plays out, the bench sets the format pins to the second byte's format. It then follows the line tick by tick across the junction between the two characters. Random frames also change the format pins after each launch and vary the gap between ticks. This exercises the capture at launch and the rule that the line does not move between ticks.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  input  logic              done_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o,
  output logic              hold_empty_o,
  output logic              tx_empty_o
);
  logic [DATA_W-1:0] data_q;
  logic              full_q, wr_q, hold_empty_q, tx_empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q       <= '0;
      full_q       <= 1'b0;
      wr_q         <= 1'b0;
      hold_empty_q <= 1'b1;
      tx_empty_q   <= 1'b1;
    end else begin
      wr_q <= wr_i;
      if (wr_i) data_q <= data_i;
      if (wr_i)        full_q <= 1'b1;
      else if (take_i) full_q <= 1'b0;
      // visible flags lag the write by one edge
      if (take_i && !wr_i) hold_empty_q <= 1'b1;
      else if (wr_q)       hold_empty_q <= 1'b0;
      if (wr_q)        tx_empty_q <= 1'b0;
      else if (done_i) tx_empty_q <= 1'b1;
    end
  end

  assign full_o       = full_q;
  assign data_o       = data_q;
  assign hold_empty_o = hold_empty_q;
  assign tx_empty_o   = tx_empty_q;
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              hold_full_i,
  input  logic [DATA_W-1:0] hold_data_i,
  input  logic [1:0]        char_len_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic              stop_two_i,
  output logic              take_o,
  output logic              done_o,
  output logic              line_o
);
  localparam int CNT_W = $clog2(2 * TICKS_PER_BIT);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LIM_ONE  = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] LIM_HALF = CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2 - 1);
  localparam logic [CNT_W-1:0] LIM_TWO  = CNT_W'(2 * TICKS_PER_BIT - 1);

  tx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q, slim_q, slim_d;
  logic [BIT_W-1:0]  bit_q, last_q;
  logic [DATA_W-1:0] sh_q, mask_d;
  logic              pen_q, pbit_q, pbit_d;
  logic              bit_end, stop_end;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) mask_d[i] = (i <= 32'(char_len_i) + 4);
  end

  assign pbit_d   = (^(hold_data_i & mask_d)) ^ ~par_even_i;
  assign slim_d   = !stop_two_i ? LIM_ONE : (char_len_i == 2'd0) ? LIM_HALF : LIM_TWO;
  assign bit_end  = (cnt_q == LIM_ONE);
  assign stop_end = (state_q == ST_STOP) && (cnt_q == slim_q);
  assign take_o   = tick_i && hold_full_i && (state_q == ST_IDLE || stop_end);
  assign done_o   = tick_i && stop_end && !hold_full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      last_q  <= '0;
      sh_q    <= '0;
      pen_q   <= 1'b0;
      pbit_q  <= 1'b0;
      slim_q  <= '0;
    end else if (tick_i) begin
      if (take_o) begin
        state_q <= ST_START;
        cnt_q   <= '0;
        sh_q    <= hold_data_i;
        last_q  <= BIT_W'(char_len_i) + BIT_W'(4);
        pen_q   <= par_en_i;
        pbit_q  <= pbit_d;
        slim_q  <= slim_d;
      end else begin
        unique case (state_q)
          ST_IDLE: cnt_q <= '0;
          ST_START:
            if (bit_end) begin
              state_q <= ST_DATA;
              cnt_q   <= '0;
              bit_q   <= '0;
            end else cnt_q <= cnt_q + CNT_W'(1);
          ST_DATA:
            if (bit_end) begin
              cnt_q <= '0;
              sh_q  <= sh_q >> 1;
              if (bit_q == last_q) state_q <= pen_q ? ST_PAR : ST_STOP;
              else bit_q <= bit_q + BIT_W'(1);
            end else cnt_q <= cnt_q + CNT_W'(1);
          ST_PAR:
            if (bit_end) begin
              state_q <= ST_STOP;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + CNT_W'(1);
          ST_STOP:
            if (stop_end) begin
              state_q <= ST_IDLE;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + CNT_W'(1);
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = sh_q[0];
      ST_PAR:   line_o = pbit_q;
      default:  line_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core #(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              hold_wr_i,
  input  logic [DATA_W-1:0] hold_data_i,
  input  logic [1:0]        char_len_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic              stop_two_i,
  input  logic              break_i,
  output logic              txd_o,
  output logic              hold_empty_o,
  output logic              tx_empty_o
);
  logic              hold_full, take, done, line;
  logic [DATA_W-1:0] hold_data;

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (hold_wr_i),
    .data_i      (hold_data_i),
    .take_i      (take),
    .done_i      (done),
    .full_o      (hold_full),
    .data_o      (hold_data),
    .hold_empty_o(hold_empty_o),
    .tx_empty_o  (tx_empty_o)
  );

  uart_tx_shift #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .hold_full_i(hold_full),
    .hold_data_i(hold_data),
    .char_len_i (char_len_i),
    .par_en_i   (par_en_i),
    .par_even_i (par_even_i),
    .stop_two_i (stop_two_i),
    .take_o     (take),
    .done_o     (done),
    .line_o     (line)
  );

  assign txd_o = line & ~break_i;
endmodule

// File: rtl/uart_tx_core_chk.sv
module uart_tx_core_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic hold_wr_i,
  input logic break_i,
  input logic txd_o,
  input logic hold_empty_o,
  input logic tx_empty_o
);
  AST_BREAK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_i |-> !txd_o); // R9
  AST_LINE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(tick_i) && $stable(break_i)) |-> $stable(txd_o)); // R11
  AST_FLAGS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_wr_i |=> ##1 !tx_empty_o); // R6
  AST_NO_EARLY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_wr_i && tx_empty_o && !$past(hold_wr_i)) |=> tx_empty_o); // R6
  AST_EMPTY_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> hold_empty_o); // R8
  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_empty_o && !break_i) |-> txd_o); // R8
endmodule

bind uart_tx_core uart_tx_core_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .hold_wr_i   (hold_wr_i),
  .break_i     (break_i),
  .txd_o       (txd_o),
  .hold_empty_o(hold_empty_o),
  .tx_empty_o  (tx_empty_o)
);

// File: tb/uart_tx_core_bench.sv
module uart_tx_core_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0, hold_wr_i = 1'b0, par_en_i = 1'b0, par_even_i = 1'b0;
  logic       stop_two_i = 1'b0, break_i = 1'b0;
  logic [7:0] hold_data_i = 8'h00;
  logic [1:0] char_len_i = 2'd0;
  logic       txd_o, hold_empty_o, tx_empty_o;

  int checks = 0;
  int errors = 0;
  int gap_max = 0;
  logic lv[0:15];
  int   du[0:15];
  int   nlv;

  always #10 clk_i = ~clk_i;

  uart_tx_core u_uart_tx_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .hold_wr_i(hold_wr_i),
    .hold_data_i(hold_data_i), .char_len_i(char_len_i), .par_en_i(par_en_i),
    .par_even_i(par_even_i), .stop_two_i(stop_two_i), .break_i(break_i),
    .txd_o(txd_o), .hold_empty_o(hold_empty_o), .tx_empty_o(tx_empty_o)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_parity(input logic [7:0] d, input int len, input logic even);
    logic p = 1'b0;
    for (int b = 0; b < len; b++) p ^= d[b];
    return even ? p : ~p;
  endfunction

  // expected levels and durations in ticks
  task automatic build(input logic [7:0] d, input logic [1:0] lc, input logic pe,
                       input logic pev, input logic s2);
    int len = 5 + int'(lc);
    nlv = 0;
    lv[nlv] = 1'b0; du[nlv] = 16; nlv++;
    for (int b = 0; b < len; b++) begin lv[nlv] = d[b]; du[nlv] = 16; nlv++; end
    if (pe) begin lv[nlv] = exp_parity(d, len, pev); du[nlv] = 16; nlv++; end
    lv[nlv] = 1'b1;
    du[nlv] = !s2 ? 16 : (lc == 2'd0) ? 24 : 32;
    nlv++;
  endtask

  task automatic tick_step();
    int gap = (gap_max == 0) ? 0 : int'($urandom_range(gap_max, 0));
    logic seen;
    @(negedge clk_i) tick_i = 1'b1;
    @(negedge clk_i) tick_i = 1'b0;
    seen = txd_o;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk_i);
      chk(txd_o, seen, "R11 line moved between ticks");
    end
  endtask

  task automatic set_cfg(input logic [1:0] lc, input logic pe, input logic pev, input logic s2);
    char_len_i = lc; par_en_i = pe; par_even_i = pev; stop_two_i = s2;
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk_i) begin hold_wr_i = 1'b1; hold_data_i = d; end
    @(negedge clk_i) hold_wr_i = 1'b0;
  endtask

  // write into idle block, check flag timing, then launch
  task automatic launch_idle(input logic [7:0] d);
    write_byte(d);
    chk(hold_empty_o, 1'b1, "R6 hold_empty after write edge");
    chk(tx_empty_o, 1'b1, "R6 tx_empty after write edge");
    @(negedge clk_i);
    chk(hold_empty_o, 1'b0, "R6 hold_empty after second edge");
    chk(tx_empty_o, 1'b0, "R6 tx_empty after second edge");
    repeat (2) @(negedge clk_i);
    chk(txd_o, 1'b1, "R5 no launch without tick");
    tick_step();
    chk(txd_o, 1'b0, "R5 start bit at first tick");
    chk(hold_empty_o, 1'b1, "R6 hold_empty set on transfer");
    chk(tx_empty_o, 1'b0, "R6 tx_empty low while shifting");
  endtask

  // walk the built frame; start bit already on the line
  task automatic play(input logic next_lvl, input int brk_lo, input int brk_hi);
    int k = 0;
    for (int i = 0; i < nlv; i++) begin
      for (int t = 1; t <= du[i]; t++) begin
        logic e;
        k++;
        break_i = (k >= brk_lo) && (k < brk_hi);
        tick_step();
        e = (t < du[i]) ? lv[i] : ((i + 1 < nlv) ? lv[i + 1] : next_lvl);
        if (break_i) chk(txd_o, 1'b0, "R9 break forces low");
        else chk(txd_o, e, "R2 R3 R4 frame level");
      end
    end
    break_i = 1'b0;
  endtask

  task automatic frame(input logic [7:0] d, input logic [1:0] lc, input logic pe,
                       input logic pev, input logic s2, input int brk_lo, input int brk_hi);
    set_cfg(lc, pe, pev, s2);
    build(d, lc, pe, pev, s2);
    launch_idle(d);
    set_cfg(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom)); // R10 pins change mid-frame
    play(1'b1, brk_lo, brk_hi);
    chk(tx_empty_o, 1'b1, "R8 tx_empty after last stop");
    chk(hold_empty_o, 1'b1, "R8 hold_empty after last stop");
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0451));
    repeat (3) @(negedge clk_i);
    chk(txd_o, 1'b1, "R1 line in reset");
    chk(hold_empty_o, 1'b1, "R1 hold_empty in reset");
    chk(tx_empty_o, 1'b1, "R1 tx_empty in reset");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(txd_o, 1'b1, "R1 line after reset");
    chk(tx_empty_o, 1'b1, "R1 tx_empty after reset");

    // R2 R4 8 bits, no parity, one stop
    frame(8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 0, 0);
    // R3 R4 5 bits even parity, 1.5 stop
    frame(8'h13, 2'd0, 1'b1, 1'b1, 1'b1, 0, 0);
    // R3 R4 6 bits odd parity, two stop
    frame(8'h2D, 2'd1, 1'b1, 1'b0, 1'b1, 0, 0);
    // R3 upper bits outside 7-bit char must not affect parity
    frame(8'hC3, 2'd2, 1'b1, 1'b1, 1'b0, 0, 0);

    // R9 break while idle
    @(negedge clk_i) break_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(txd_o, 1'b0, "R9 break while idle");
    chk(tx_empty_o, 1'b1, "R9 break leaves tx_empty");
    @(negedge clk_i) break_i = 1'b0;
    @(negedge clk_i);
    chk(txd_o, 1'b1, "R9 line back high after break");

    // R9 break mid-frame, timing keeps running
    frame(8'h5A, 2'd3, 1'b1, 1'b0, 1'b0, 20, 45);

    // R7 back-to-back characters
    gap_max = 1;
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    build(8'h81, 2'd3, 1'b0, 1'b0, 1'b0);
    launch_idle(8'h81);
    write_byte(8'h3C);
    @(negedge clk_i);
    chk(hold_empty_o, 1'b0, "R7 second byte held");
    set_cfg(2'd0, 1'b1, 1'b0, 1'b1); // format of the second byte, captured at its launch
    play(1'b0, 0, 0);
    chk(hold_empty_o, 1'b1, "R7 held byte moved at stop end");
    chk(tx_empty_o, 1'b0, "R7 still busy with second byte");
    build(8'h3C, 2'd0, 1'b1, 1'b0, 1'b1);
    set_cfg(2'd3, 1'b0, 1'b1, 1'b0); // R10
    play(1'b1, 0, 0);
    chk(tx_empty_o, 1'b1, "R8 idle after second byte");

    // random frames
    gap_max = 2;
    for (int n = 0; n < 14; n++) begin
      frame(8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 0, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule